// File: doc/BRIEF.md
# Decade-Range Gate Pulse Generator

This block turns a rising edge on a start input into a gate of programmable length. The length comes from two inputs: a decade range select, where each step is ten times longer than the one before, and a fine multiplier given in hundredths. The gate appears on a pair of complementary logic outputs. When it ends, a recovery period begins. A delayed-out pulse marks that period, and its length depends on which pair of ranges was in use.

A stop input can end a timed gate early. It also blocks new starts for as long as it is held. A veto input forces the logic outputs inactive but leaves the timing untouched. A range code just past the last decade puts the block in latching mode, where the gate stays open until a stop arrives. Range and multiplier are captured when a start is accepted. Later start edges are ignored until the block has returned to idle.

Top module: `gg_decade_gate`

## Requirements
- R1: Reset state. During and after synchronous reset, `logic_o`=0, `logic_n_o`=1 and `dly_o`=0, and the block is idle.
- R2: Timed gate length. For a range code r below `NUM_RANGES`, `logic_o` rises at the clock edge that samples the rising edge of `start_i`. It stays high for floor(`BASE0_TICKS`·10^r·m/`MULT_UNIT`) cycles, where m is the clamped multiplier.
- R3: Multiplier clamp. Values below `MULT_MIN` act as `MULT_MIN`, and values above `MULT_MAX` act as `MULT_MAX`.
- R4: Start inhibit. A start edge sampled while `stop_i`=1 opens no gate. That edge is used up, so releasing stop while start is still high opens no gate either.
- R5: Early stop. When `stop_i`=1 is sampled during a gate, the gate ends at that edge and recovery follows at once.
- R6: Latching mode. A range code of `NUM_RANGES` or more holds the gate open until stop is sampled. The recovery that follows uses the length of range pair 0.
- R7: Veto. `veto_i` sampled high at an edge forces `logic_o` low (and `logic_n_o` high) for the following cycle. It does not move the end of the gate or the recovery.
- R8: `logic_n_o` is always the complement of `logic_o`.
- R9: Recovery pulse. `dly_o` rises at the edge that ends the gate. It stays high for `REC_TICKS[r/2]` cycles and is not masked by veto.
- R10: Edge sensitivity. A start input held high through the end of the gate and the recovery does not start another gate.
- R11: Start edges that arrive during a gate or during recovery are ignored.
- R12: Range and multiplier are sampled when the start is accepted. Changing them during the gate does not change its length or the length of the recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one timing tick per cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start; its rising edge opens a gate |
| stop_i | input | 1 | Ends a gate; blocks starts while high |
| veto_i | input | 1 | Masks the logic outputs only |
| range_i | input | RANGE_W (4) | Decade select 0..NUM_RANGES-1; higher codes select latching |
| mult_i | input | MULT_W (11) | Fine multiplier in hundredths |
| logic_o | output | 1 | Gate, true sense |
| logic_n_o | output | 1 | Gate, complementary sense |
| dly_o | output | 1 | Recovery (delayed-out) pulse |

## Verification
Single start pulses are sent over several ranges and multipliers: an exact multiple, a value that truncates, and values below and above the clamp limits. Together these separate the decade scaling, the truncating division and the clamp. For every pulse the bench records the cycle in which the recovery begins. This catches any extra or missing cycle and any wrong recovery length for a range pair. Further patterns hold stop before start, hold start past the end of the gate, toggle start during the gate and during recovery, and change range and multiplier in mid-gate. Each of these isolates one ignore rule. Partial and full veto show that the logic outputs are masked while the recovery start stays in the same cycle. Early stop and latching are checked against the recovery length of the range pair in use.

// File: rtl/gg_pkg.sv
package gg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GATE  = 2'd1,
    ST_RECOV = 2'd2
  } gg_state_e;

  // 10 raised to e, for elaboration-time tables
  function automatic longint unsigned gg_pow10(input int unsigned e);
    longint unsigned p;
    p = 1;
    for (int i = 0; i < int'(e); i++) p = p * 10;
    return p;
  endfunction

  // number of bits needed to hold v (at least one)
  function automatic int unsigned gg_bits(input longint unsigned v);
    int unsigned b;
    b = 1;
    for (int i = 1; i < 64; i++) if ((v >> i) != 0) b = i + 1;
    return b;
  endfunction

endpackage

// File: rtl/gg_start_edge.sv
module gg_start_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sig_i,
  output logic rise_o
);

  logic prev_q;

  // prev resets high: a start held through reset is not an edge
  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b1;
    else       prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;

  // R10: one edge yields one pulse, never two in a row
  p_single_rise_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);

endmodule

// File: rtl/gg_width_timer.sv
module gg_width_timer
  import gg_pkg::*;
#(
  parameter int unsigned NUM_RANGES  = 8,
  parameter int unsigned RANGE_W     = 4,
  parameter int unsigned RIDX_W      = 3,
  parameter int unsigned PAIR_W      = 2,
  parameter int unsigned BASE0_TICKS = 10,
  parameter int unsigned MULT_W      = 11,
  parameter int unsigned MULT_UNIT   = 100,
  parameter int unsigned MULT_MIN    = 100,
  parameter int unsigned MULT_MAX    = 1100,
  parameter int unsigned REM_W       = 37
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               load_i,
  input  logic               run_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic [MULT_W-1:0]  mult_i,
  output logic               expire_o,
  output logic               latch_o,
  output logic [PAIR_W-1:0]  pair_o
);

  localparam logic [REM_W-1:0] UNIT_R = REM_W'(MULT_UNIT);
  localparam logic [REM_W-1:0] TWO_R  = REM_W'(2 * MULT_UNIT);

  // decade base lengths in ticks, one per range
  logic [REM_W-1:0] base_tbl [NUM_RANGES];
  for (genvar g = 0; g < int'(NUM_RANGES); g++) begin : g_base
    localparam longint unsigned BV = longint'(BASE0_TICKS) * gg_pow10(g);
    assign base_tbl[g] = REM_W'(BV);
  end

  logic              is_latch;
  logic [MULT_W-1:0] mult_c;
  logic [REM_W-1:0]  base_sel;
  logic [REM_W-1:0]  target;

  assign is_latch = (range_i >= RANGE_W'(NUM_RANGES));

  always_comb begin
    if (mult_i < MULT_W'(MULT_MIN))      mult_c = MULT_W'(MULT_MIN);
    else if (mult_i > MULT_W'(MULT_MAX)) mult_c = MULT_W'(MULT_MAX);
    else                                 mult_c = mult_i;
  end

  assign base_sel = is_latch ? '0 : base_tbl[range_i[RIDX_W-1:0]];
  // remaining length kept in hundredths of a tick: no divider needed
  assign target   = base_sel * REM_W'(mult_c);

  logic [REM_W-1:0]  rem_q;
  logic              latch_q;
  logic [PAIR_W-1:0] pair_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rem_q   <= '0;
      latch_q <= 1'b0;
      pair_q  <= '0;
    end else if (load_i) begin
      rem_q   <= target;
      latch_q <= is_latch;
      pair_q  <= is_latch ? '0 : range_i[RIDX_W-1:1];
    end else if (run_i && !latch_q) begin
      rem_q   <= rem_q - UNIT_R;
    end
  end

  assign expire_o = run_i && !latch_q && (rem_q < TWO_R);
  assign latch_o  = latch_q;
  assign pair_o   = pair_q;

  // R2: a timed gate never runs below one tick of remaining length
  p_rem_floor_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && !latch_q) |-> (rem_q >= UNIT_R));

  // R12: captured settings never reload while a gate is running
  p_no_reload_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    run_i |-> !load_i);

endmodule

// File: rtl/gg_recovery_timer.sv
module gg_recovery_timer #(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned PAIR_W    = 2,
  parameter int unsigned REC_W     = 20,
  parameter int unsigned REC_TICKS [NUM_PAIRS] = '{7, 100, 9500, 950000}
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [PAIR_W-1:0] pair_i,
  output logic              done_o
);

  logic [REC_W-1:0] last_tbl [NUM_PAIRS];
  for (genvar g = 0; g < int'(NUM_PAIRS); g++) begin : g_len
    assign last_tbl[g] = REC_W'(REC_TICKS[g] - 1);
  end

  logic [REC_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                       cnt_q <= '0;
    else if (load_i)                 cnt_q <= last_tbl[pair_i];
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);

  // R9: recovery is never reloaded while it is counting
  p_rec_excl_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    run_i |-> !load_i);

endmodule

// File: rtl/gg_out_stage.sv
module gg_out_stage (
  input  logic clk_i,
  input  logic rst_i,
  input  logic gate_nxt_i,
  input  logic dly_nxt_i,
  input  logic veto_i,
  output logic logic_o,
  output logic logic_n_o,
  output logic dly_o
);

  logic shown;
  assign shown = gate_nxt_i & ~veto_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      logic_o   <= 1'b0;
      logic_n_o <= 1'b1;
      dly_o     <= 1'b0;
    end else begin
      logic_o   <= shown;
      logic_n_o <= ~shown;
      dly_o     <= dly_nxt_i;
    end
  end

  // R7: veto seen at an edge keeps the gate hidden for the next cycle
  p_veto_mask_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(veto_i) |-> !logic_o);

  // R8: the two logic outputs never agree
  p_compl_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    logic_o != logic_n_o);

endmodule

// File: rtl/gg_decade_gate.sv
module gg_decade_gate
  import gg_pkg::*;
#(
  parameter int unsigned NUM_RANGES  = 8,
  parameter int unsigned BASE0_TICKS = 10,
  parameter int unsigned MULT_W      = 11,
  parameter int unsigned MULT_UNIT   = 100,
  parameter int unsigned MULT_MIN    = 100,
  parameter int unsigned MULT_MAX    = 1100,
  parameter int unsigned REC_TICKS [NUM_RANGES/2] = '{7, 100, 9500, 950000},
  parameter int unsigned RANGE_W     = gg_bits(longint'(NUM_RANGES))
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               veto_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic [MULT_W-1:0]  mult_i,
  output logic               logic_o,
  output logic               logic_n_o,
  output logic               dly_o
);

  localparam int unsigned NUM_PAIRS = NUM_RANGES / 2;
  localparam int unsigned RIDX_W    = gg_bits(longint'(NUM_RANGES - 1));
  localparam int unsigned PAIR_W    = RIDX_W - 1;
  localparam longint unsigned TGT_MAX =
    longint'(BASE0_TICKS) * gg_pow10(NUM_RANGES - 1) * longint'(MULT_MAX);
  localparam int unsigned REM_W     = gg_bits(TGT_MAX);

  function automatic longint unsigned rec_max();
    longint unsigned m;
    m = 1;
    for (int i = 0; i < int'(NUM_PAIRS); i++)
      if (longint'(REC_TICKS[i]) > m) m = longint'(REC_TICKS[i]);
    return m;
  endfunction

  localparam int unsigned REC_W = gg_bits(rec_max());

  logic              start_rise;
  logic              expire;
  logic              latched;
  logic [PAIR_W-1:0] pair;
  logic              rec_done;
  logic              accept;
  logic              rec_load;
  gg_state_e         state_q, state_d;

  gg_start_edge u_edge (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sig_i  (start_i),
    .rise_o (start_rise)
  );

  assign accept = (state_q == ST_IDLE) && start_rise && !stop_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)              state_d = ST_GATE;
      ST_GATE:  if (stop_i || expire)    state_d = ST_RECOV;
      ST_RECOV: if (rec_done)            state_d = ST_IDLE;
      default:                           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= ST_IDLE;
    else       state_q <= state_d;
  end

  assign rec_load = (state_q == ST_GATE) && (state_d == ST_RECOV);

  gg_width_timer #(
    .NUM_RANGES  (NUM_RANGES),
    .RANGE_W     (RANGE_W),
    .RIDX_W      (RIDX_W),
    .PAIR_W      (PAIR_W),
    .BASE0_TICKS (BASE0_TICKS),
    .MULT_W      (MULT_W),
    .MULT_UNIT   (MULT_UNIT),
    .MULT_MIN    (MULT_MIN),
    .MULT_MAX    (MULT_MAX),
    .REM_W       (REM_W)
  ) u_width (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (accept),
    .run_i    (state_q == ST_GATE),
    .range_i  (range_i),
    .mult_i   (mult_i),
    .expire_o (expire),
    .latch_o  (latched),
    .pair_o   (pair)
  );

  gg_recovery_timer #(
    .NUM_PAIRS (NUM_PAIRS),
    .PAIR_W    (PAIR_W),
    .REC_W     (REC_W),
    .REC_TICKS (REC_TICKS)
  ) u_recov (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (rec_load),
    .run_i  (state_q == ST_RECOV),
    .pair_i (pair),
    .done_o (rec_done)
  );

  gg_out_stage u_out (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .gate_nxt_i (state_d == ST_GATE),
    .dly_nxt_i  (state_d == ST_RECOV),
    .veto_i     (veto_i),
    .logic_o    (logic_o),
    .logic_n_o  (logic_n_o),
    .dly_o      (dly_o)
  );

  // R4: stop held in idle keeps the gate shut
  p_stop_inhibit_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_IDLE && stop_i) |=> (state_q != ST_GATE));

  // R5: stop during a gate closes it at that edge
  p_stop_ends_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_GATE && stop_i) |=> (state_q == ST_RECOV));

  // R6: a latched gate only closes through stop
  p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_GATE && latched && !stop_i) |=> (state_q == ST_GATE));

  // R9: recovery output is up once the gate has closed
  p_recov_follows_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_RECOV && $past(state_q) == ST_GATE) |-> dly_o);

  // R11: recovery never leads straight back into a gate
  p_no_retrig_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_RECOV) |=> (state_q != ST_GATE));

  // R2: the true output is only high inside a gate
  p_logic_in_gate_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    logic_o |-> (state_q == ST_GATE));

endmodule

// File: tb/gg_decade_gate_tb_top.sv
module gg_decade_gate_tb_top;

  localparam int unsigned NR = 8;
  localparam int unsigned B0 = 1;
  localparam int unsigned MW = 11;
  localparam int unsigned RW = 4;
  localparam int unsigned RECT [4] = '{7, 20, 45, 90};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, stop = 1'b0, veto = 1'b0;
  logic [RW-1:0] rng = '0;
  logic [MW-1:0] mult = 11'd100;
  logic          lo, lno, dly;

  always #2 clk = ~clk;

  gg_decade_gate #(
    .NUM_RANGES  (NR),
    .BASE0_TICKS (B0),
    .MULT_W      (MW),
    .REC_TICKS   ('{7, 20, 45, 90})
  ) dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .start_i   (start),
    .stop_i    (stop),
    .veto_i    (veto),
    .range_i   (rng),
    .mult_i    (mult),
    .logic_o   (lo),
    .logic_n_o (lno),
    .dly_o     (dly)
  );

  typedef struct {
    int    gate;
    int    rec;
    int    at;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0, cyc = 0, pulses = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int glen(input int r, input int m);
    longint b;
    int mc;
    b = B0;
    for (int i = 0; i < r; i++) b = b * 10;
    mc = (m < 100) ? 100 : ((m > 1100) ? 1100 : m);
    return int'((b * mc) / 100);
  endfunction

  function automatic int rlen(input int r);
    return (r >= int'(NR)) ? int'(RECT[0]) : int'(RECT[r / 2]);
  endfunction

  // monitor: gather one pulse, compare on the fall of the recovery output
  int  g_cnt = 0, d_cnt = 0, d_at = 0, c_err = 0;
  bit  in_d = 1'b0;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (lo == lno) c_err++;
        if (lo) g_cnt++;
        if (dly) begin
          if (!in_d) begin
            in_d = 1'b1;
            d_at = cyc;
          end
          d_cnt++;
        end else if (in_d) begin
          pulses++;
          if (sb.size() == 0) begin
            chk(1'b0, "R11", "unexpected pulse", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(g_cnt == e.gate, e.tag, "gate cycles", g_cnt, e.gate);
            chk(d_cnt == e.rec, "R9", "recovery cycles", d_cnt, e.rec);
            chk(d_at == e.at, e.tag, "recovery start cycle", d_at, e.at);
            chk(c_err == 0, "R8", "complement errors", c_err, 0);
          end
          g_cnt = 0; d_cnt = 0; c_err = 0; in_d = 1'b0;
        end
      end
    end
  end

  // driver: one plain start pulse, expected item pushed at launch
  task automatic fire(input int r, input int m, input string tag);
    int g;
    @(negedge clk);
    rng = RW'(r); mult = MW'(m); start = 1'b1;
    g = glen(r, m);
    sb.push_back('{g, rlen(r), cyc + g + 1, tag});
    @(negedge clk);
    start = 1'b0;
    repeat (g + rlen(r) + 3) @(negedge clk);
  endtask

  initial begin
    begin : watchdog
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0, c;
    repeat (5) @(negedge clk);
    // R1: outputs during reset
    chk(lo == 1'b0, "R1", "logic_o in reset", lo, 0);
    chk(lno == 1'b1, "R1", "logic_n_o in reset", lno, 1);
    chk(dly == 1'b0, "R1", "dly_o in reset", dly, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(lo == 1'b0 && dly == 1'b0, "R1", "idle after reset", lo, 0);

    // R2: range/multiplier patterns
    fire(0, 100, "R2");
    fire(1, 250, "R2");
    fire(0, 1050, "R2");
    fire(2, 1100, "R2");
    fire(3, 150, "R2");
    fire(4, 100, "R2");
    // R3: clamp below and above
    fire(1, 50, "R3");
    fire(1, 2000, "R3");

    // R5: early stop on range 6, five gate cycles
    @(negedge clk);
    rng = 4'd6; mult = 11'd100; start = 1'b1; c = cyc;
    sb.push_back('{5, rlen(6), c + 6, "R5"});
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    repeat (rlen(6) + 5) @(negedge clk);

    // R6: latching mode held for 39 cycles, then stop
    @(negedge clk);
    rng = 4'd8; mult = 11'd100; start = 1'b1; c = cyc;
    sb.push_back('{39, rlen(8), c + 40, "R6"});
    @(negedge clk); start = 1'b0;
    repeat (38) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    repeat (rlen(8) + 5) @(negedge clk);

    // R4: start edge under stop is consumed
    p0 = pulses;
    @(negedge clk); stop = 1'b1; rng = 4'd1; mult = 11'd100;
    @(negedge clk); start = 1'b1;
    repeat (3) @(negedge clk);
    stop = 1'b0;
    repeat (30) @(negedge clk);
    chk(lo == 1'b0, "R4", "logic_o after inhibited start", lo, 0);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(pulses == p0, "R4", "pulses after inhibited start", pulses, p0);

    // R10: start held high past gate and recovery
    p0 = pulses;
    @(negedge clk);
    rng = 4'd0; mult = 11'd300; start = 1'b1; c = cyc;
    sb.push_back('{3, rlen(0), c + 4, "R10"});
    repeat (40) @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(pulses == p0 + 1, "R10", "pulses with held start", pulses, p0 + 1);

    // R11: extra edges inside gate and inside recovery
    p0 = pulses;
    @(negedge clk);
    rng = 4'd1; mult = 11'd200; start = 1'b1; c = cyc;
    sb.push_back('{20, rlen(1), c + 21, "R11"});
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (16) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    chk(pulses == p0 + 1, "R11", "pulses with extra edges", pulses, p0 + 1);

    // R12: settings changed mid-gate
    @(negedge clk);
    rng = 4'd1; mult = 11'd200; start = 1'b1; c = cyc;
    sb.push_back('{20, rlen(1), c + 21, "R12"});
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rng = 4'd2; mult = 11'd1100;
    repeat (30) @(negedge clk);

    // R7: partial veto, 10 of 30 gate cycles hidden
    @(negedge clk);
    rng = 4'd1; mult = 11'd300; start = 1'b1; c = cyc;
    sb.push_back('{20, rlen(1), c + 31, "R7"});
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    veto = 1'b1;
    repeat (10) @(negedge clk);
    veto = 1'b0;
    repeat (30) @(negedge clk);

    // R7: veto over the whole gate, recovery still on time
    @(negedge clk);
    rng = 4'd1; mult = 11'd100; start = 1'b1; veto = 1'b1; c = cyc;
    sb.push_back('{0, rlen(1), c + 11, "R7"});
    @(negedge clk); start = 1'b0;
    repeat (15) @(negedge clk);
    veto = 1'b0;
    repeat (15) @(negedge clk);

    chk(sb.size() == 0, "R9", "missing recovery pulses", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule